// File: doc/BRIEF.md
# Lock-Guarded Page Write Controller

This block takes an already decoded stream of bus commands and turns it into writes on a 512-byte synchronous memory. A transfer opens with a start command that carries a byte address. Data bytes follow and are collected in a 16-entry page buffer. A stop command then ends the transfer. Only the low four address bits advance from byte to byte, so a long burst wraps around inside its 16-byte page and never crosses into the next page.

A small lock register is held apart from the memory. It names a read-only region at the top of the array: a quarter, a half or all of it, or the last 16, 32, 64 or 128 bytes. Bytes aimed at that region are acknowledged and then dropped. A write-protect pin freezes the lock register and leaves the region read-only. If a transfer keeps at least one byte, the block runs a self-timed commit window of `WR_TICKS` cycles, which stands in for the few milliseconds a real cell write takes. While that window runs, `busy` is high and no command is acknowledged.

Top module: `wpc_page_writer`

## Requirements
- R1: After reset, `cmd_ack` and `busy` are 0 and `lock_cfg` is 3'b000, so nothing is protected.
- R2: Command codes on `cmd_op` are 1 start, 2 data, 3 stop, 4 lock write and 5 read. Start, lock write and read are accepted only when no transfer is open. Data and stop are accepted only inside an open transfer. `cmd_ack` is high for exactly the one cycle after an accepted command. A command that is not accepted gets no ack and has no effect.
- R3: An accepted read presents the memory byte at `cmd_addr` on `rd_data` in the same cycle as its ack.
- R4: In a transfer opened at address A, data byte k targets {A[8:4], (A[3:0]+k) mod 16}. When two bytes in one transfer hit the same slot, the later byte is the one stored.
- R5: When `lock_cfg[2]`=0, `lock_cfg[1:0]` selects the protected range: 0 none, 1 addresses 384..511, 2 addresses 256..511, 3 the whole array.
- R6: When `lock_cfg[2]`=1, the top 16<<`lock_cfg[1:0]` bytes are protected (16, 32, 64 or 128).
- R7: A data byte whose target is protected is still acknowledged, but it is never written to memory.
- R8: An accepted stop that follows at least one unprotected byte raises `busy` in the ack cycle. `busy` then stays high for exactly `WR_TICKS` cycles. A stop that follows no unprotected byte leaves `busy` low and writes nothing.
- R9: While `busy` is high, no command is acknowledged and none has any effect.
- R10: While `wp` is 1, a lock write is acknowledged but leaves `lock_cfg` unchanged. Protected bytes stay unwritten, and unprotected bytes are still written.
- R11: With `wp` at 0, an accepted lock write loads `cmd_data[2:0]` into `lock_cfg`, visible from the ack cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Byte address for start and read |
| cmd_data | input | DATA_W | Data byte, or lock value in bits 2:0 |
| wp | input | 1 | Write-protect pin, active high |
| cmd_ack | output | 1 | Acknowledge for the previous cycle's command |
| busy | output | 1 | Self-timed commit window in progress |
| rd_data | output | DATA_W | Read result |
| lock_cfg | output | 3 | Current lock setting |

## Verification
The assertions assume that `cmd_op` carries only the five listed codes or 0. They also assume that `lock_cfg` cannot change during a commit window, which R9 guarantees, so the decoder on the commit path sees the same setting that filtered the bytes. The stimulus presents one command at a time and drops `cmd_valid` after each one. It changes `wp` only between transfers. It issues commands during a commit window only to confirm that they are refused.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_START = 3'd1,
    OP_DATA  = 3'd2,
    OP_STOP  = 3'd3,
    OP_LOCK  = 3'd4,
    OP_READ  = 3'd5
  } wpc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BUSY
  } wpc_state_e;
endpackage

// File: rtl/wpc_lock_decode.sv
module wpc_lock_decode #(
  parameter int AW            = 9,
  parameter int TOP_MIN_BYTES = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    cfg,
  output logic          hit
);
  localparam logic [AW:0] DEPTH_V  = (AW+1)'(1 << AW);
  localparam logic [AW:0] TOPMIN_V = (AW+1)'(TOP_MIN_BYTES);

  logic [AW:0] thr;

  always_comb begin
    if (!cfg[2]) begin
      unique case (cfg[1:0])
        2'd0:    thr = DEPTH_V;
        2'd1:    thr = DEPTH_V - (DEPTH_V >> 2);
        2'd2:    thr = DEPTH_V >> 1;
        default: thr = '0;
      endcase
    end else begin
      thr = DEPTH_V - (TOPMIN_V << cfg[1:0]);
    end
    hit = ({1'b0, addr} >= thr);
  end
endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DW         = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_keep,
  input  logic [OFF_W-1:0] rd_off,
  output logic [DW-1:0]    rd_data,
  output logic             rd_keep,
  output logic             any_keep
);
  logic [DW-1:0]         slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  keep_q <= '0;
    else if (wr_en)  keep_q[wr_off] <= wr_keep;
  end

  assign rd_data  = slot_q[rd_off];
  assign rd_keep  = keep_q[rd_off];
  assign any_keep = |keep_q;
endmodule

// File: rtl/wpc_array_ram.sv
module wpc_array_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wpc_page_writer.sv
module wpc_page_writer
  import wpc_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 8,
  parameter int PAGE_BYTES    = 16,
  parameter int WR_TICKS      = 40,
  parameter int TOP_MIN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wp,
  output logic              cmd_ack,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        lock_cfg
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(WR_TICKS + 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_TICKS - 1);

  wpc_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        lock_q;
  logic              ack_q, busy_q;

  wpc_op_e op;
  logic    legal, accept;
  assign op = wpc_op_e'(cmd_op);

  always_comb begin
    unique case (state_q)
      ST_IDLE: legal = (op == OP_START) || (op == OP_LOCK) || (op == OP_READ);
      ST_OPEN: legal = (op == OP_DATA) || (op == OP_STOP);
      default: legal = 1'b0;
    endcase
  end
  assign accept = cmd_valid && legal;

  // incoming byte: protection check at its wrapped address
  logic prot_in;
  wpc_lock_decode #(.AW(ADDR_W), .TOP_MIN_BYTES(TOP_MIN_BYTES)) u_dec_in (
    .addr(ADDR_W'({page_q, off_q})), .cfg(lock_q), .hit(prot_in)
  );

  logic              commit, ram_we, slot_keep, any_keep;
  logic [DATA_W-1:0] slot_data;
  logic [ADDR_W-1:0] waddr;
  assign commit = (state_q == ST_BUSY) && (cnt_q < PAGE_CNT);
  assign waddr  = {page_q, cnt_q[OFF_W-1:0]};
  assign ram_we = commit && slot_keep;

  wpc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DW(DATA_W)) u_buf (
    .clk(clk), .rst(rst),
    .clr(accept && op == OP_START),
    .wr_en(accept && op == OP_DATA),
    .wr_off(off_q), .wr_data(cmd_data), .wr_keep(!prot_in),
    .rd_off(cnt_q[OFF_W-1:0]), .rd_data(slot_data), .rd_keep(slot_keep),
    .any_keep(any_keep)
  );

  wpc_array_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(slot_data),
    .re(accept && op == OP_READ), .raddr(cmd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      lock_q  <= 3'b000;
      ack_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      ack_q <= accept;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (op == OP_START) begin
            page_q  <= cmd_addr[ADDR_W-1:OFF_W];
            off_q   <= cmd_addr[OFF_W-1:0];
            state_q <= ST_OPEN;
          end else if (op == OP_LOCK && !wp) begin
            lock_q <= cmd_data[2:0];
          end
        end
        ST_OPEN: if (accept) begin
          if (op == OP_DATA) begin
            off_q <= off_q + 1'b1;
          end else if (any_keep) begin
            state_q <= ST_BUSY;
            busy_q  <= 1'b1;
            cnt_q   <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_CNT) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end
        end
      endcase
    end
  end

  assign cmd_ack  = ack_q;
  assign busy     = busy_q;
  assign lock_cfg = lock_q;

  // independent decode of the commit address
  logic prot_commit;
  wpc_lock_decode #(.AW(ADDR_W), .TOP_MIN_BYTES(TOP_MIN_BYTES)) u_dec_commit (
    .addr(waddr), .cfg(lock_q), .hit(prot_commit)
  );

  a_r9_no_ack_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> !cmd_ack);

  a_r10_wp_freezes_lock: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LOCK && wp |=> $stable(lock_cfg));

  a_r7_commit_outside_lock: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !prot_commit);

  a_r8_cycle_needs_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_op == OP_STOP));

  a_r8_busy_acked: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cmd_ack);
endmodule

// File: tb/wpc_page_writer_tb.sv
module wpc_page_writer_tb_top;
  localparam int WR_TICKS = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       wp = 1'b0;
  logic       cmd_ack, busy;
  logic [7:0] rd_data;
  logic [2:0] lock_cfg;

  always #2 clk = ~clk;

  wpc_page_writer #(.WR_TICKS(WR_TICKS)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp(wp),
    .cmd_ack(cmd_ack), .busy(busy), .rd_data(rd_data), .lock_cfg(lock_cfg)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] ref_mem [512];
  logic [2:0] ref_cfg = 3'b000;
  logic       last_ack;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit prot_ref(input int a, input logic [2:0] c);
    if (!c[2]) begin
      case (c[1:0])
        2'd0: return 1'b0;
        2'd1: return a >= 384;
        2'd2: return a >= 256;
        default: return 1'b1;
      endcase
    end
    return a >= 512 - (16 << c[1:0]);
  endfunction

  task automatic issue(input logic [2:0] op, input int a, input int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 9'(a); cmd_data = 8'(d);
    @(negedge clk);
    last_ack  = cmd_ack;
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic rd(input int a, input string req);
    issue(3'd5, a, 0);
    chk(req, last_ack, 1);
    chk(req, rd_data, ref_mem[a]);
  endtask

  task automatic lock_write(input logic [2:0] v);
    issue(3'd4, 0, v);
    chk("R2", last_ack, 1);
    if (!wp) ref_cfg = v;
    chk(wp ? "R10" : "R11", lock_cfg, ref_cfg);
  endtask

  // one transfer; hold=1 returns right after the stop without waiting
  task automatic page_write(input int a, input int n, input int seed,
                            input bit hold, input string req);
    bit any = 0;
    issue(3'd1, a, 0);
    chk("R2", last_ack, 1);
    for (int k = 0; k < n; k++) begin
      int t = (a & 9'h1F0) | ((a + k) & 15);
      issue(3'd2, 0, seed + k);
      chk("R7", last_ack, 1);
      if (!prot_ref(t, ref_cfg)) begin
        ref_mem[t] = 8'(seed + k);
        any = 1;
      end
    end
    issue(3'd3, 0, 0);
    chk("R2", last_ack, 1);
    if (hold) return;
    if (any) begin
      int cyc = 0;
      while (busy && cyc < 1000) begin
        cyc++;
        @(negedge clk);
      end
      chk(req, cyc, WR_TICKS);
    end else begin
      chk(req, busy, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1", cmd_ack, 0);
    chk("R1", busy, 0);
    chk("R1", lock_cfg, 0);
    issue(3'd2, 0, 8'h33);
    chk("R2", last_ack, 0);
    issue(3'd3, 0, 0);
    chk("R2", last_ack, 0);
  endtask

  task automatic t_basic;
    page_write(9'h020, 4, 8'h11, 0, "R8");
    for (int i = 0; i < 4; i++) rd(9'h020 + i, "R3");
  endtask

  task automatic t_wrap;
    page_write(9'h040, 1, 8'hA0, 0, "R8");
    page_write(9'h03E, 5, 8'h50, 0, "R4");
    rd(9'h03E, "R4"); rd(9'h03F, "R4"); rd(9'h030, "R4");
    rd(9'h031, "R4"); rd(9'h032, "R4"); rd(9'h040, "R4");
    page_write(9'h055, 18, 8'h70, 0, "R4");
    rd(9'h055, "R4"); rd(9'h056, "R4"); rd(9'h050, "R4"); rd(9'h05F, "R4");
  endtask

  task automatic t_prefill;
    int bases[9] = '{9'h000, 9'h0F0, 9'h100, 9'h170, 9'h180,
                     9'h1B0, 9'h1C0, 9'h1E0, 9'h1F0};
    foreach (bases[i]) page_write(bases[i], 2, 8'h80 + 2 * i, 0, "R8");
  endtask

  task automatic probe(input logic [2:0] v, input int locked, input int open,
                       input int seed, input string req);
    lock_write(v);
    page_write(locked, 2, seed, 0, "R8");
    rd(locked, req); rd(locked + 1, req);
    page_write(open, 2, seed + 8, 0, "R8");
    rd(open, req); rd(open + 1, req);
  endtask

  task automatic t_lock_coarse;
    probe(3'b001, 9'h180, 9'h170, 8'hC0, "R5");
    probe(3'b010, 9'h100, 9'h0F0, 8'hC4, "R5");
    lock_write(3'b011);
    page_write(9'h000, 3, 8'hD0, 0, "R7");
    rd(9'h000, "R5");
    lock_write(3'b000);
    page_write(9'h1F0, 1, 8'hD8, 0, "R5");
    rd(9'h1F0, "R5");
  endtask

  task automatic t_lock_top;
    probe(3'b100, 9'h1F0, 9'h1E0, 8'h20, "R6");
    probe(3'b101, 9'h1E0, 9'h1C0, 8'h30, "R6");
    probe(3'b110, 9'h1C0, 9'h1B0, 8'h40, "R6");
    probe(3'b111, 9'h180, 9'h170, 8'h50, "R6");
  endtask

  task automatic t_wp;
    lock_write(3'b001);
    wp = 1'b1;
    lock_write(3'b000);
    page_write(9'h180, 2, 8'hE0, 0, "R10");
    rd(9'h180, "R10");
    page_write(9'h170, 2, 8'hE4, 0, "R10");
    rd(9'h170, "R10");
    wp = 1'b0;
    lock_write(3'b000);
  endtask

  task automatic t_busy;
    int cyc = 0;
    page_write(9'h060, 2, 8'h90, 1, "R9");
    chk("R8", busy, 1);
    issue(3'd5, 9'h020, 0);
    chk("R9", last_ack, 0);
    issue(3'd4, 0, 3'b011);
    chk("R9", last_ack, 0);
    chk("R9", lock_cfg, ref_cfg);
    issue(3'd1, 9'h070, 0);
    chk("R9", last_ack, 0);
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    chk("R9", lock_cfg, ref_cfg);
    issue(3'd2, 0, 8'h99);
    chk("R9", last_ack, 0);
    rd(9'h060, "R9"); rd(9'h061, "R9");
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_wrap;
    t_prefill;
    t_lock_coarse;
    t_lock_top;
    t_wp;
    t_busy;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule